// File: doc/BRIEF.md
# Shared Serial Converter Controller

This block runs one serial bus (clock, data out, data in) that is shared by two converters. Each converter has its own active-low chip select. The first converter is a dual-channel 12-bit DAC that sets the reference levels of two comparators. It accepts a 16-bit write-only frame. The second converter is a multi-input 12-bit successive-approximation ADC, used to self-check the test voltage and both references. Its frame is full duplex: during each frame the controller sends the next command, and the converter returns the result of its previous conversion. After each ADC frame the controller waits for the converter's end-of-conversion flag before it reports a result.

A parent module gives the block a 16-bit command word and a device select over a valid/ready channel. A command is taken only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while the engine is idle, so a command offered while a frame is in progress is not taken and has no effect on the bus. The 12-bit ADC result leaves on a second valid/ready channel. `res_valid` stays high with `res_data` stable until the parent raises `res_ready`, and the engine stays busy until then. `done` pulses for one cycle each time the engine returns to idle.

Inside, a main sequencer steers a half-period tick generator and a 16-bit shift unit. The serial clock half-period is set by `sclk_half` and is sampled when a command is accepted.

Top module: `sconv_ctrl`

## Requirements
- R1: With `cmd_dev`=0 the block lowers `cs_dac_n` only. It gives exactly 16 SCLK pulses and presents `cmd_word` MSB first on `si`, with each bit stable across its SCLK falling edge.
- R2: With `cmd_dev`=1 the block lowers `cs_adc_n` only. It gives exactly 16 SCLK pulses, with `cmd_word` MSB first on `si` and each bit stable across its SCLK rising edge. `so` is sampled once per bit, while SCLK is high.
- R3: The ADC result equals the first 12 of the 16 bits received on `so`, the first received bit being the result MSB. The last 4 received bits are discarded.
- R4: At most one chip select is low at any time. SCLK is low whenever both chip selects are high.
- R5: Each SCLK high phase and low phase lasts H system clocks, where H = `sclk_half` if `sclk_half` ≥ 2 and H = 2 otherwise. The chip select goes low exactly H clocks before the first rising edge and returns high exactly H clocks after the last falling edge.
- R6: `cmd_ready` is high only when idle. A `cmd_valid` presented while busy is not taken: no second frame starts and the current frame is not altered.
- R7: After an ADC frame releases its chip select, `res_valid` stays low until `adc_eoc` has been seen high. It rises on the clock after `adc_eoc` is sampled high.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold. The handshake returns the engine to idle.
- R9: `done` is a single-cycle pulse. It comes in the cycle the engine is idle again: at chip-select release for a DAC frame, and after the result handshake for an ADC frame.
- R10: After reset both chip selects are high, SCLK and `si` are low, `cmd_ready` is high, and `res_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_half | input | DIV_W | SCLK half-period in system clocks (minimum 2), taken at command accept |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_word | input | FRAME_BITS | Word shifted out MSB first |
| cmd_dev | input | 1 | Target device: 0 = DAC, 1 = ADC |
| res_valid | output | 1 | ADC result available |
| res_ready | input | 1 | Parent takes the result |
| res_data | output | RES_BITS | ADC result |
| done | output | 1 | One-cycle pulse on return to idle |
| sclk | output | 1 | Shared serial clock |
| si | output | 1 | Shared serial data to the converters |
| so | input | 1 | Serial data from the ADC |
| cs_dac_n | output | 1 | DAC chip select, active low |
| cs_adc_n | output | 1 | ADC chip select, active low |
| adc_eoc | input | 1 | ADC end-of-conversion flag |

## Verification
The bench models both converters at the pins. The DAC model samples `si` on falling edges and the ADC model on rising edges, and the ADC model shifts a chosen pattern out on falling edges. A design that changed `si` on the same edge that a device samples would deliver a corrupted word. The bench measures every half-period, the lead time and the trail time, including the clamp for `sclk_half` values of 0 and 1. An off-by-one in the divider, or a chip select released too early, shows up as a wrong width. It holds `adc_eoc` low for varying times and stalls `res_ready`, so a result reported before end-of-conversion or dropped under back-pressure is caught. Commands offered in mid-frame check that a busy engine neither restarts nor switches device.

// File: rtl/sconv_pkg.sv
`timescale 1ns/1ps
package sconv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_EOCW,
    ST_RESP
  } seq_st_t;

  typedef enum logic {
    DEV_DAC = 1'b0,
    DEV_ADC = 1'b1
  } dev_t;

  localparam int MIN_HALF = 2;
endpackage

// File: rtl/sconv_halfgen.sv
`timescale 1ns/1ps
module sconv_halfgen
  import sconv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] half_cfg,
  input  logic             run,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MINV = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt;

  // latch the clamped half-period when a command is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= MINV;
    end else if (load) begin
      half_q <= (half_cfg < MINV) ? MINV : half_cfg;
    end
  end

  assign tick = run && (cnt == half_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sconv_shifter.sv
`timescale 1ns/1ps
module sconv_shifter #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  shift,
  input  logic                  capture,
  input  logic                  sdi,
  output logic                  sdo,
  output logic [FRAME_BITS-1:0] rx_word
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [FRAME_BITS-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
    end else if (shift) begin
      tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (load) begin
      rx_q <= '0;
    end else if (capture) begin
      rx_q <= {rx_q[FRAME_BITS-2:0], sdi};
    end
  end

  assign sdo     = tx_q[FRAME_BITS-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/sconv_seq.sv
`timescale 1ns/1ps
module sconv_seq
  import sconv_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_dev,
  input  logic                  tick,
  input  logic                  eoc,
  input  logic                  res_ready,
  input  logic [FRAME_BITS-1:0] rx_word,
  output logic                  cmd_ready,
  output logic                  load,
  output logic                  shift,
  output logic                  capture,
  output logic                  run,
  output logic                  sclk,
  output logic                  cs_dac_n,
  output logic                  cs_adc_n,
  output logic                  res_valid,
  output logic [RES_BITS-1:0]   res_data,
  output logic                  done
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  seq_st_t          state;
  dev_t             dev_q;
  logic             sclk_q;
  logic             fall_d;
  logic [CNT_W-1:0] bitcnt;

  assign cmd_ready = (state == ST_IDLE);
  assign load      = cmd_valid && (state == ST_IDLE);
  assign run       = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL);
  assign capture   = (state == ST_SHIFT) && tick && sclk_q;
  // next bit goes out one system clock after the falling edge
  assign shift     = fall_d;
  assign sclk      = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dev_q     <= DEV_DAC;
      sclk_q    <= 1'b0;
      fall_d    <= 1'b0;
      bitcnt    <= '0;
      cs_dac_n  <= 1'b1;
      cs_adc_n  <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      fall_d <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            dev_q  <= dev_t'(cmd_dev);
            bitcnt <= '0;
            if (cmd_dev == DEV_ADC) cs_adc_n <= 1'b0;
            else                    cs_dac_n <= 1'b0;
            state  <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sclk_q <= 1'b1;
            state  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
              fall_d <= 1'b1;
              if (bitcnt == LAST_BIT) state <= ST_TRAIL;
              else                    bitcnt <= bitcnt + 1'b1;
            end else begin
              sclk_q <= 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_dac_n <= 1'b1;
            cs_adc_n <= 1'b1;
            if (dev_q == DEV_ADC) begin
              state <= ST_EOCW;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_EOCW: begin
          if (eoc) begin
            res_data  <= rx_word[FRAME_BITS-1 -: RES_BITS];
            res_valid <= 1'b1;
            state     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sconv_ctrl.sv
`timescale 1ns/1ps
module sconv_ctrl #(
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12,
  parameter int DIV_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      sclk_half,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [FRAME_BITS-1:0] cmd_word,
  input  logic                  cmd_dev,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [RES_BITS-1:0]   res_data,
  output logic                  done,
  output logic                  sclk,
  output logic                  si,
  input  logic                  so,
  output logic                  cs_dac_n,
  output logic                  cs_adc_n,
  input  logic                  adc_eoc
);
  logic                  load;
  logic                  shift;
  logic                  capture;
  logic                  run;
  logic                  tick;
  logic [FRAME_BITS-1:0] rx_word;

  sconv_halfgen #(.DIV_W(DIV_W)) u_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .half_cfg (sclk_half),
    .run      (run),
    .tick     (tick)
  );

  sconv_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (cmd_word),
    .shift     (shift),
    .capture   (capture),
    .sdi       (so),
    .sdo       (si),
    .rx_word   (rx_word)
  );

  sconv_seq #(.FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_dev   (cmd_dev),
    .tick      (tick),
    .eoc       (adc_eoc),
    .res_ready (res_ready),
    .rx_word   (rx_word),
    .cmd_ready (cmd_ready),
    .load      (load),
    .shift     (shift),
    .capture   (capture),
    .run       (run),
    .sclk      (sclk),
    .cs_dac_n  (cs_dac_n),
    .cs_adc_n  (cs_adc_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .done      (done)
  );
endmodule

// File: rtl/sconv_ctrl_chk.sv
`timescale 1ns/1ps
module sconv_ctrl_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_ready,
  input logic                res_valid,
  input logic                res_ready,
  input logic [RES_BITS-1:0] res_data,
  input logic                done,
  input logic                sclk,
  input logic                si,
  input logic                cs_dac_n,
  input logic                cs_adc_n,
  input logic                adc_eoc
);
  a_r1_si_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(si));

  a_r2_si_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(si));

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_dac_n && !cs_adc_n));

  a_r4_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_dac_n && cs_adc_n) |-> !sclk);

  a_r5_lead_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(!cs_dac_n || !cs_adc_n));

  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_dac_n || !cs_adc_n) |-> !cmd_ready);

  a_r7_result_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(adc_eoc));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !res_valid));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sconv_ctrl sconv_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .done      (done),
  .sclk      (sclk),
  .si        (si),
  .cs_dac_n  (cs_dac_n),
  .cs_adc_n  (cs_adc_n),
  .adc_eoc   (adc_eoc)
);

// File: tb/sconv_ctrl_tb.sv
`timescale 1ns/1ps
module sconv_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sclk_half;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [15:0] cmd_word;
  logic        cmd_dev;
  logic        res_valid;
  logic        res_ready;
  logic [11:0] res_data;
  logic        done;
  logic        sclk;
  logic        si;
  logic        so;
  logic        cs_dac_n;
  logic        cs_adc_n;
  logic        adc_eoc;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk; // 250 MHz

  sconv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_half(sclk_half),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_dev(cmd_dev),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .done(done),
    .sclk(sclk), .si(si), .so(so), .cs_dac_n(cs_dac_n), .cs_adc_n(cs_adc_n),
    .adc_eoc(adc_eoc)
  );

  // converter pin models
  int          falls = 0;
  int          adc_base = 0;
  logic [15:0] adc_pat = 16'h0;
  logic [15:0] dac_rx = 16'h0;
  logic [15:0] adc_rx = 16'h0;

  always @(negedge sclk) falls = falls + 1;
  always @(negedge cs_adc_n) adc_base = falls;
  always @(negedge sclk) if (!cs_dac_n) dac_rx = {dac_rx[14:0], si};
  always @(posedge sclk) if (!cs_adc_n) adc_rx = {adc_rx[14:0], si};
  always @* begin
    int k;
    k = falls - adc_base;
    so = (!cs_adc_n && k >= 0 && k < 16) ? adc_pat[15 - k] : 1'b0;
  end

  function automatic int eff_half(input logic [7:0] h);
    return (h < 8'd2) ? 2 : int'(h);
  endfunction

  function automatic logic [11:0] exp_result(input logic [15:0] pat);
    return pat[15:4];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input bit dev, input logic [15:0] w, input logic [15:0] pat,
                       input logic [7:0] hcfg, input int eoc_dly, input int rdy_dly, input bit poke);
    int h, t, t_rise1, last_t, nr, nf;
    bit bad_w, both_low, other_low, eoc_dropped, prev, held;
    logic [11:0] exp;
    h = eff_half(hcfg);
    @(negedge clk);
    sclk_half = hcfg; adc_pat = pat; cmd_word = w; cmd_dev = dev; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R6 ready while idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk((dev ? cs_adc_n : cs_dac_n) == 1'b0, dev ? "R2 select low" : "R1 select low", dev ? cs_adc_n : cs_dac_n, 0);
    chk(cmd_ready == 1'b0, "R6 busy not ready", cmd_ready, 0);
    t = 0; t_rise1 = -1; last_t = 0; nr = 0; nf = 0; prev = sclk;
    bad_w = 0; both_low = 0; other_low = 0; eoc_dropped = 0;
    while ((!cs_dac_n || !cs_adc_n) && t < 20000) begin
      if (!cs_dac_n && !cs_adc_n) both_low = 1;
      if ((dev ? cs_dac_n : cs_adc_n) == 1'b0) other_low = 1;
      if (poke && t == 3 * h) begin cmd_valid = 1'b1; cmd_dev = ~dev; cmd_word = ~w; end
      if (poke && t == 3 * h + 2) cmd_valid = 1'b0;
      if (dev && nf == 16 && !eoc_dropped) begin adc_eoc = 1'b0; eoc_dropped = 1; end
      @(negedge clk);
      t++;
      if (sclk && !prev) begin
        nr++;
        if (nr == 1) t_rise1 = t; else if (t - last_t != h) bad_w = 1;
        last_t = t;
      end
      if (!sclk && prev) begin
        nf++;
        if (t - last_t != h) bad_w = 1;
        last_t = t;
      end
      prev = sclk;
    end
    cmd_valid = 1'b0;
    chk(t < 20000, "R5 frame ends", t, 0);
    chk(nr == 16 && nf == 16, dev ? "R2 sixteen clocks" : "R1 sixteen clocks", nf, 16);
    chk(t_rise1 == h, "R5 lead time", t_rise1, h);
    chk(t - last_t == h, "R5 trail time", t - last_t, h);
    chk(!bad_w, "R5 half-period width", bad_w, 0);
    chk(!both_low && !other_low, "R4 single select", {both_low, other_low}, 0);
    chk(sclk == 1'b0, "R4 sclk parked", sclk, 0);
    if (!dev) begin
      chk(dac_rx == w, "R1 DAC word", dac_rx, w);
      chk(done && cmd_ready, "R9 done at release", {done, cmd_ready}, 3);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
    end else begin
      chk(adc_rx == w, "R2 ADC command word", adc_rx, w);
      held = 1;
      for (int i = 0; i < eoc_dly + 1; i++) begin
        if (res_valid || done) held = 0;
        @(negedge clk);
      end
      chk(held && !res_valid, "R7 no result before eoc", res_valid, 0);
      adc_eoc = 1'b1;
      @(negedge clk);
      exp = exp_result(pat);
      chk(res_valid, "R7 result after eoc", res_valid, 1);
      chk(res_data == exp, "R3 top twelve bits", res_data, exp);
      held = 1;
      for (int i = 0; i < rdy_dly; i++) begin
        @(negedge clk);
        if (!res_valid || res_data != exp || done) held = 0;
      end
      chk(held, "R8 hold under back-pressure", res_data, exp);
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      chk(!res_valid && done && cmd_ready, "R8 handshake to idle", {res_valid, done, cmd_ready}, 3);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
    end
    if (poke) begin
      repeat (4 * h) @(negedge clk);
      chk(cs_dac_n && cs_adc_n && cmd_ready, "R6 busy command ignored", {cs_dac_n, cs_adc_n}, 3);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; sclk_half = 8'd2; cmd_valid = 1'b0; cmd_word = 16'h0; cmd_dev = 1'b0;
    res_ready = 1'b0; adc_eoc = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_dac_n && cs_adc_n && !sclk && !si, "R10 reset pins", {cs_dac_n, cs_adc_n, sclk, si}, 4'b1100);
    chk(cmd_ready && !res_valid && !done, "R10 reset status", {cmd_ready, res_valid, done}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_dac_n && cs_adc_n && !sclk && cmd_ready, "R10 after release", {cs_dac_n, cs_adc_n, sclk}, 6);

    frame(1'b0, 16'hA5C3, 16'h0, 8'd2, 0, 0, 1'b0);
    frame(1'b0, 16'hFFFF, 16'h0, 8'd0, 0, 0, 1'b0);
    frame(1'b0, 16'h0001, 16'h0, 8'd1, 0, 0, 1'b0);
    frame(1'b1, 16'h8000, 16'hFFF0, 8'd3, 0, 0, 1'b0);
    frame(1'b1, 16'h7FFF, 16'h000F, 8'd2, 7, 3, 1'b0);
    frame(1'b1, 16'h3C5A, 16'h8001, 8'd9, 2, 1, 1'b0);
    frame(1'b0, 16'h1234, 16'h0, 8'd4, 0, 0, 1'b1);
    frame(1'b1, 16'h5678, 16'hBEEF, 8'd3, 4, 2, 1'b1);

    for (int n = 0; n < 24; n++) begin
      frame(1'($urandom), 16'($urandom), 16'($urandom), 8'($urandom_range(0, 7)),
            int'($urandom_range(0, 9)), int'($urandom_range(0, 5)), 1'($urandom_range(0, 3) == 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule